// File: doc/BRIEF.md
# Programmable Expansion Bus Cycle Sequencer

This block runs single access cycles on an asynchronous expansion-card bus. It takes its timing from a 64 MHz master clock. The host offers a request on a valid/ready port. The request carries a direction flag, an address and write data. The block then walks the bus through five timed phases and drives an active-low card select and one active-low read or write strobe. It captures read data and reports completion with a one-clock response pulse. The response has no ready input and cannot be back-pressured: the host must take `rsp_valid`/`rsp_rdata` in the cycle they appear, although `rsp_rdata` stays valid until the next read completes. A request is accepted on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` is low for the whole of a cycle in progress. A `req_valid` seen while not ready is dropped and is not queued.

A four-bit speed register picks one of eight timing profiles. Each profile sets the length, in master clocks, of every phase. Software writes a code with `spd_wr`. A code outside the supported range is refused, and `spd_err` tells software to retry with the next slower code. The profile is snapshotted when a request is accepted, so a speed write never alters a cycle that is already running.

Top module: `exp_bus_seq`

## Requirements
- R1: Speed code c selects the phase lengths (run-in / select lead / strobe low / select tail / run-out, in clocks) from this table. 1: 4/6/16/6/4 (36 total). 2: 4/6/12/2/4 (28). 3: 4/2/8/2/4 (20). 4: 4/2/4/2/4 (16). 5: 2/3/8/3/2 (18). 6: 2/3/6/1/2 (14). 7: 2/1/4/1/2 (10). 8: 2/1/2/1/2 (8).
- R2: During a cycle the phases come in a fixed order. Run-in keeps `bus_cs_n`=1 and both strobes at 1. Select lead has `bus_cs_n`=0 with both strobes at 1. Strobe low has `bus_cs_n`=0 and one strobe at 0. Select tail has `bus_cs_n`=0 with both strobes at 1. Run-out has everything at 1. While idle, all three pins are 1.
- R3: Only one strobe is driven low in a cycle: `bus_wr_n` when `req_write`=1 was accepted, otherwise `bus_rd_n`. The two are never low together.
- R4: `bus_addr`, `bus_dout` and the direction are captured on the accepting edge and held unchanged for the whole cycle. `bus_dout` equals the accepted `req_wdata`.
- R5: For a read, `rsp_rdata` holds the `bus_din` value present in the last clock of the strobe-low phase.
- R6: `busy` is high for exactly the profile's total clock count, starting the clock after acceptance. `rsp_valid` is high for one clock right after `busy` falls, and then the block is idle.
- R7: `req_ready` is low whenever `busy` is high. A `req_valid` given during a cycle neither starts a second cycle nor alters the bus outputs.
- R8: A `spd_wr` with code 0 or 9..15 sets `spd_err`=1 and leaves `spd_cur` unchanged. A `spd_wr` with code 1..8 loads `spd_cur` and clears `spd_err`.
- R9: A speed write in the middle of a cycle, or on the same edge that accepts a request, affects only later cycles.
- R10: After reset `bus_cs_n`, `bus_rd_n` and `bus_wr_n` are 1, `busy`, `rsp_valid` and `spd_err` are 0, `req_ready` is 1 and `spd_cur` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 64 MHz master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host offers an access |
| req_ready | output | 1 | Block can accept an access (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DW | Captured read data |
| busy | output | 1 | Cycle in progress |
| spd_wr | input | 1 | Speed register write strobe |
| spd_code | input | 4 | Requested speed code |
| spd_cur | output | 4 | Speed code in force |
| spd_err | output | 1 | Last speed write was refused |
| bus_cs_n | output | 1 | Active-low card select |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_addr | output | AW | Held bus address |
| bus_dout | output | DW | Held write data |
| bus_din | input | DW | Read data from the card |

## Verification
A speed-register write and a request acceptance can fall on the same clock edge. A speed write can also land on any clock of a running cycle. The bench provokes the first by raising `spd_wr` and `req_valid` in the same cycle, moving from the slowest to the fastest profile and back. It provokes the second by writing a new code several clocks into a cycle. In both cases it measures the phase lengths from the pins and requires the current cycle to follow the old profile and the next cycle to follow the new one. The bench also places a second `req_valid` inside a running cycle and checks that no extra cycle follows.

// File: rtl/exp_bus_pkg.sv
package exp_bus_pkg;

  localparam int LEN_W  = 5;
  localparam int CODE_W = 4;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RUNIN,
    PH_LEAD,
    PH_PULSE,
    PH_TAIL,
    PH_RUNOUT
  } phase_e;

  typedef struct packed {
    logic [LEN_W-1:0] runin;
    logic [LEN_W-1:0] lead;
    logic [LEN_W-1:0] pulse;
    logic [LEN_W-1:0] tail;
    logic [LEN_W-1:0] runout;
  } prof_t;

  function automatic logic code_ok(input logic [CODE_W-1:0] c);
    return (c != '0) && (c <= 4'd8);
  endfunction

  // Phase lengths in master clocks for each supported speed code.
  function automatic prof_t prof_of(input logic [CODE_W-1:0] c);
    prof_t p;
    case (c)
      4'd2:    p = '{5'd4, 5'd6, 5'd12, 5'd2, 5'd4};
      4'd3:    p = '{5'd4, 5'd2, 5'd8,  5'd2, 5'd4};
      4'd4:    p = '{5'd4, 5'd2, 5'd4,  5'd2, 5'd4};
      4'd5:    p = '{5'd2, 5'd3, 5'd8,  5'd3, 5'd2};
      4'd6:    p = '{5'd2, 5'd3, 5'd6,  5'd1, 5'd2};
      4'd7:    p = '{5'd2, 5'd1, 5'd4,  5'd1, 5'd2};
      4'd8:    p = '{5'd2, 5'd1, 5'd2,  5'd1, 5'd2};
      default: p = '{5'd4, 5'd6, 5'd16, 5'd6, 5'd4};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/exp_speed_reg.sv
module exp_speed_reg
  import exp_bus_pkg::*;
#(
  parameter logic [CODE_W-1:0] RESET_CODE = 4'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] cur,
  output logic              err,
  output prof_t             prof
);

  logic [CODE_W-1:0] cur_q;
  logic              err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= RESET_CODE;
      err_q <= 1'b0;
    end else if (wr) begin
      if (code_ok(code)) begin
        cur_q <= code;
        err_q <= 1'b0;
      end else begin
        err_q <= 1'b1;
      end
    end
  end

  assign cur  = cur_q;
  assign err  = err_q;
  assign prof = prof_of(cur_q);

endmodule

// File: rtl/exp_phase_timer.sv
module exp_phase_timer
  import exp_bus_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  prof_t  prof_in,
  output phase_e phase,
  output phase_e phase_nxt,
  output logic   last,
  output logic   done
);

  phase_e           ph_q, ph_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] lead_q, pulse_q, tail_q, runout_q;
  logic             done_q;

  assign last = (cnt_q == '0);

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (ph_q == PH_IDLE) begin
      if (start) begin
        ph_d  = PH_RUNIN;
        cnt_d = prof_in.runin - 5'd1;
      end
    end else if (!last) begin
      cnt_d = cnt_q - 5'd1;
    end else begin
      case (ph_q)
        PH_RUNIN: begin ph_d = PH_LEAD;   cnt_d = lead_q   - 5'd1; end
        PH_LEAD:  begin ph_d = PH_PULSE;  cnt_d = pulse_q  - 5'd1; end
        PH_PULSE: begin ph_d = PH_TAIL;   cnt_d = tail_q   - 5'd1; end
        PH_TAIL:  begin ph_d = PH_RUNOUT; cnt_d = runout_q - 5'd1; end
        default:  begin ph_d = PH_IDLE;   cnt_d = '0;              end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      cnt_q    <= '0;
      lead_q   <= 5'd1;
      pulse_q  <= 5'd1;
      tail_q   <= 5'd1;
      runout_q <= 5'd1;
      done_q   <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      done_q <= (ph_q == PH_RUNOUT) && last;
      if (ph_q == PH_IDLE && start) begin
        lead_q   <= prof_in.lead;
        pulse_q  <= prof_in.pulse;
        tail_q   <= prof_in.tail;
        runout_q <= prof_in.runout;
      end
    end
  end

  assign phase     = ph_q;
  assign phase_nxt = ph_d;
  assign done      = done_q;

endmodule

// File: rtl/exp_bus_seq.sv
module exp_bus_seq
  import exp_bus_pkg::*;
#(
  parameter int                AW         = 12,
  parameter int                DW         = 16,
  parameter logic [CODE_W-1:0] RESET_CODE = 4'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic              busy,
  input  logic              spd_wr,
  input  logic [CODE_W-1:0] spd_code,
  output logic [CODE_W-1:0] spd_cur,
  output logic              spd_err,
  output logic              bus_cs_n,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [AW-1:0]     bus_addr,
  output logic [DW-1:0]     bus_dout,
  input  logic [DW-1:0]     bus_din
);

  prof_t   prof;
  phase_e  phase, phase_nxt;
  logic    last, done, accept;

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          write_q, cs_n_q, rd_n_q, wr_n_q;

  exp_speed_reg #(.RESET_CODE(RESET_CODE)) u_spd (
    .clk  (clk),
    .rst_n(rst_n),
    .wr   (spd_wr),
    .code (spd_code),
    .cur  (spd_cur),
    .err  (spd_err),
    .prof (prof)
  );

  exp_phase_timer u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .prof_in  (prof),
    .phase    (phase),
    .phase_nxt(phase_nxt),
    .last     (last),
    .done     (done)
  );

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign busy      = !req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      write_q <= req_write;
    end
  end

  // Strobes are registered from the next phase so the pins are glitch-free.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_q <= 1'b1;
      rd_n_q <= 1'b1;
      wr_n_q <= 1'b1;
    end else begin
      cs_n_q <= !(phase_nxt inside {PH_LEAD, PH_PULSE, PH_TAIL});
      rd_n_q <= !(phase_nxt == PH_PULSE && !write_q);
      wr_n_q <= !(phase_nxt == PH_PULSE &&  write_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata_q <= '0;
    else if (phase == PH_PULSE && last && !write_q)
      rdata_q <= bus_din;
  end

  assign bus_cs_n  = cs_n_q;
  assign bus_rd_n  = rd_n_q;
  assign bus_wr_n  = wr_n_q;
  assign bus_addr  = addr_q;
  assign bus_dout  = wdata_q;
  assign rsp_valid = done;
  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/exp_bus_seq_chk.sv
module exp_bus_seq_chk #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          busy,
  input logic          rsp_valid,
  input logic          spd_wr,
  input logic [3:0]    spd_code,
  input logic [3:0]    spd_cur,
  input logic          spd_err,
  input logic          bus_cs_n,
  input logic          bus_rd_n,
  input logic          bus_wr_n,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_dout
);

  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));

  assert_strobe_in_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || !bus_wr_n) |-> !bus_cs_n);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bus_cs_n && bus_rd_n && bus_wr_n));

  assert_hold_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || ($stable(bus_addr) && $stable(bus_dout))));

  assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $fell(busy));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_not_ready_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  assert_bad_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (spd_wr && (spd_code == 4'd0 || spd_code > 4'd8)) |=> (spd_err && $stable(spd_cur)));

  assert_good_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (spd_wr && spd_code != 4'd0 && spd_code <= 4'd8) |=> (!spd_err && spd_cur == $past(spd_code)));

endmodule

bind exp_bus_seq exp_bus_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .busy     (busy),
  .rsp_valid(rsp_valid),
  .spd_wr   (spd_wr),
  .spd_code (spd_code),
  .spd_cur  (spd_cur),
  .spd_err  (spd_err),
  .bus_cs_n (bus_cs_n),
  .bus_rd_n (bus_rd_n),
  .bus_wr_n (bus_wr_n),
  .bus_addr (bus_addr),
  .bus_dout (bus_dout)
);

// File: tb/sim_exp_bus_seq.sv
`timescale 1ns/1ps
module sim_exp_bus_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [15:0] req_wdata = '0, bus_din = '0;
  logic        spd_wr = 1'b0;
  logic [3:0]  spd_code = '0;
  logic        req_ready, rsp_valid, busy, spd_err, bus_cs_n, bus_rd_n, bus_wr_n;
  logic [15:0] rsp_rdata, bus_dout;
  logic [11:0] bus_addr;
  logic [3:0]  spd_cur;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  exp_bus_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .busy(busy),
    .spd_wr(spd_wr), .spd_code(spd_code), .spd_cur(spd_cur), .spd_err(spd_err),
    .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_din(bus_din)
  );

  // Expected phase lengths per code, index 1..8 (R1).
  int e_pre  [9] = '{0, 4, 4, 4, 4, 2, 2, 2, 2};
  int e_lead [9] = '{0, 6, 6, 2, 2, 3, 3, 1, 1};
  int e_low  [9] = '{0, 16, 12, 8, 4, 8, 6, 4, 2};
  int e_tail [9] = '{0, 6, 2, 2, 2, 3, 1, 1, 1};
  int e_post [9] = '{0, 4, 4, 4, 4, 2, 2, 2, 2};

  // Measured results of the last cycle.
  int m_pre, m_lead, m_low, m_tail, m_post, m_tot, m_stage;
  logic        m_bad_strobe, m_bad_hold, m_order_bad;
  logic [15:0] m_rd_seen;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_speed(input logic [3:0] c);
    @(negedge clk);
    spd_wr = 1'b1; spd_code = c;
    @(negedge clk);
    spd_wr = 1'b0;
  endtask

  // Runs one access; optional speed write at clock spd_at (0 = with the request)
  // and an extra request at clock req_at (0 = none).
  task automatic run_cycle(input logic wr, input logic [11:0] a, input logic [15:0] d,
                           input int spd_at, input logic [3:0] spd_v, input int req_at);
    bit fin = 0;
    int k = 1;
    m_pre = 0; m_lead = 0; m_low = 0; m_tail = 0; m_post = 0; m_tot = 0; m_stage = 0;
    m_bad_strobe = 0; m_bad_hold = 0; m_order_bad = 0; m_rd_seen = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    if (spd_at == 0) begin spd_wr = 1'b1; spd_code = spd_v; end
    @(negedge clk);
    while (!fin && k < 200) begin
      req_valid = 1'b0; spd_wr = 1'b0;
      if (k == spd_at) begin spd_wr = 1'b1; spd_code = spd_v; end
      if (k == req_at) begin
        req_valid = 1'b1; req_write = !wr; req_addr = ~a; req_wdata = ~d;
      end
      if (rsp_valid) fin = 1;
      else if (busy) begin
        m_tot++;
        if (bus_addr != a || (wr && bus_dout != d)) m_bad_hold = 1;
        if (bus_cs_n) begin
          if (m_stage == 0) m_pre++;
          else begin
            if (m_stage < 3) m_order_bad = 1;
            m_stage = 4; m_post++;
          end
          if (!bus_rd_n || !bus_wr_n) m_bad_strobe = 1;
        end else if (!bus_rd_n || !bus_wr_n) begin
          if (m_stage > 2) m_order_bad = 1;
          m_stage = 2; m_low++;
          if (wr ? !bus_rd_n : !bus_wr_n) m_bad_strobe = 1;
          if (!bus_rd_n) m_rd_seen = 16'h5A00 + 16'(k);
        end else if (m_stage <= 1) begin
          m_stage = 1; m_lead++;
        end else begin
          if (m_stage > 3) m_order_bad = 1;
          m_stage = 3; m_tail++;
        end
      end
      bus_din = 16'h5A00 + 16'(k);
      if (!fin) begin
        @(negedge clk);
        k++;
      end
    end
    req_valid = 1'b0; spd_wr = 1'b0;
    chk(fin, "R6 response seen", int'(fin), 1);
  endtask

  task automatic check_prof(input int c, input string tag);
    chk(m_pre  == e_pre[c],  {tag, " R1 run-in"},      m_pre,  e_pre[c]);
    chk(m_lead == e_lead[c], {tag, " R1 select lead"}, m_lead, e_lead[c]);
    chk(m_low  == e_low[c],  {tag, " R1 strobe low"},  m_low,  e_low[c]);
    chk(m_tail == e_tail[c], {tag, " R1 select tail"}, m_tail, e_tail[c]);
    chk(m_post == e_post[c], {tag, " R1 run-out"},     m_post, e_post[c]);
    chk(m_tot == e_pre[c] + e_lead[c] + e_low[c] + e_tail[c] + e_post[c],
        {tag, " R6 busy length"}, m_tot,
        e_pre[c] + e_lead[c] + e_low[c] + e_tail[c] + e_post[c]);
    chk(!m_order_bad && m_stage == 4, {tag, " R2 phase order"}, m_stage, 4);
    chk(!m_bad_strobe, {tag, " R3 strobe choice"}, int'(m_bad_strobe), 0);
    chk(!m_bad_hold, {tag, " R4 held address/data"}, int'(m_bad_hold), 0);
  endtask

  task automatic t_reset;
    chk(bus_cs_n && bus_rd_n && bus_wr_n, "R10 strobes idle",
        {bus_cs_n, bus_rd_n, bus_wr_n}, 7);
    chk(!busy && !rsp_valid && !spd_err && req_ready, "R10 status",
        {busy, rsp_valid, spd_err, req_ready}, 1);
    chk(spd_cur == 4'd1, "R10 speed code", spd_cur, 1);
  endtask

  task automatic t_speed_table;
    for (int c = 1; c <= 8; c++) begin
      logic wr = (c % 2 == 0);
      logic [11:0] a = 12'h100 + 12'(c * 17);
      logic [15:0] d = 16'hC300 + 16'(c);
      set_speed(4'(c));
      chk(spd_cur == 4'(c) && !spd_err, "R8 accept good code", spd_cur, c);
      run_cycle(wr, a, d, -1, 4'd0, 0);
      check_prof(c, wr ? "write" : "read");
      if (!wr) chk(rsp_rdata == m_rd_seen, "R5 read data", rsp_rdata, m_rd_seen);
      @(negedge clk);
      chk(!busy && !rsp_valid && req_ready, "R6 idle after done",
          {busy, rsp_valid, req_ready}, 1);
    end
  endtask

  task automatic t_bad_codes;
    logic [3:0] bad [4] = '{4'd0, 4'd9, 4'd12, 4'd15};
    set_speed(4'd3);
    for (int i = 0; i < 4; i++) begin
      set_speed(bad[i]);
      chk(spd_err, "R8 error on unsupported code", int'(spd_err), 1);
      chk(spd_cur == 4'd3, "R8 code kept", spd_cur, 3);
    end
    run_cycle(1'b0, 12'h2A5, 16'h0, -1, 4'd0, 0);
    check_prof(3, "after refused codes");
    set_speed(4'd5);
    chk(!spd_err && spd_cur == 4'd5, "R8 error cleared by good code", int'(spd_err), 0);
  endtask

  task automatic t_busy_ignore;
    set_speed(4'd2);
    run_cycle(1'b1, 12'h3C3, 16'hBEEF, -1, 4'd0, 5);
    check_prof(2, "R7 extra request");
    @(negedge clk);
    chk(!busy && !rsp_valid, "R7 no second cycle", int'(busy), 0);
    @(negedge clk);
    chk(!busy && bus_cs_n, "R7 bus stays idle", int'(busy), 0);
  endtask

  task automatic t_midcycle_speed;
    set_speed(4'd1);
    run_cycle(1'b0, 12'h011, 16'h0, 6, 4'd8, 0);
    check_prof(1, "R9 mid-cycle write, old profile");
    chk(spd_cur == 4'd8, "R9 new code loaded", spd_cur, 8);
    run_cycle(1'b1, 12'h022, 16'h1234, -1, 4'd0, 0);
    check_prof(8, "R9 mid-cycle write, next cycle");
  endtask

  task automatic t_same_edge;
    run_cycle(1'b1, 12'h0F0, 16'h4321, 0, 4'd1, 0);
    check_prof(8, "R9 same-edge write, old profile");
    run_cycle(1'b0, 12'h0F1, 16'h0, -1, 4'd0, 0);
    check_prof(1, "R9 same-edge write, next cycle");
    chk(rsp_rdata == m_rd_seen, "R5 read data slow", rsp_rdata, m_rd_seen);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_speed_table;
    t_bad_codes;
    t_busy_ignore;
    t_midcycle_speed;
    t_same_edge;
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule